// File: doc/BRIEF.md
# Power-of-Two Weight Shifter

This block replaces a multiplier in a neuron datapath when the connection weights are limited to signed powers of two and zero. It takes an 8-bit signed activation, a one-hot select vector and a sign bit, and returns a 16-bit signed product. The activation is placed in the upper byte of the result word. The select vector then shifts it right arithmetically by a number of places, and the sign bit negates the shifted value in two's complement. Because of this, the cost is a small mux network and an incrementer rather than an array of partial products.

The deepest shift `SHIFT_MAX` (X) is a parameter from 1 to 7. The select vector is X+1 bits wide. If all select bits are clear, the weight is zero. If more than one select bit is set, the code is illegal: the product is forced to zero and an error flag is raised. The parameter `OUT_REG` chooses between two variants. With `OUT_REG` set, a clocked register holds the product and the flag, giving one cycle of latency. With `OUT_REG` clear, the path is purely combinational. The block has no state machine. Its only stored state is the optional output register, which is cleared by an active-low asynchronous reset.

Top module: `pow2w_mult`

## Requirements
- R1: At zero shift the product holds the activation in bits 15:8, and bits 7:0 are zero.
- R2: The select vector is one-hot. Bit SHIFT_MAX (the MSB) selects a shift of 0 places. Bit SHIFT_MAX-k selects an arithmetic right shift of k places, so the weight is 2^-k.
- R3: An all-zero select vector gives a product of zero and no error, for any activation and any sign.
- R4: Right shifts fill the vacated upper bits with copies of activation bit 7.
- R5: When `neg_i` is 1 and the select code is legal and nonzero, the product is the two's-complement negation of the shifted value, taken modulo 2^16.
- R6: A select vector with two or more bits set forces the product to zero and drives `err_o` to 1. For every other code, `err_o` is 0.
- R7: With `OUT_REG`=1, the product and flag appear one clock edge after the inputs. While `rst_n` is low, both outputs are 0.
- R8: For one nonzero activation such as 0x40, the legal codes give exactly 2·SHIFT_MAX+3 distinct products.
- R9: Negating the most negative aligned value (activation 0x80 at shift 0) wraps, so the product stays 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_i | input | 8 | Signed activation |
| sel_i | input | SHIFT_MAX+1 | One-hot shift select; MSB means no shift; all-zero means zero weight |
| neg_i | input | 1 | Weight sign; 1 negates the product |
| prod_o | output | 16 | Signed product |
| err_o | output | 1 | Illegal multi-hot select seen |

## Verification
There is no sequencing state to corrupt, so a wrong internal value shows up directly in `prod_o` and `err_o`. With the register enabled it appears one edge after the inputs are applied; without it, it appears at once. Two faults are the hardest to catch:
- A mis-decoded select bit gives a product off by a factor of two. Catching it needs every one-hot position to be exercised.
- A wrong fill bit only shows up with a negative activation at a nonzero shift.

The register stage is checked by looking at the outputs between the input change and the next edge.

// File: rtl/pow2w_pkg.sv
package pow2w_pkg;
    localparam int ACT_W  = 8;
    localparam int PROD_W = 16;
    localparam int PAD_W  = PROD_W - ACT_W;
endpackage

// File: rtl/pow2w_decode.sv
module pow2w_decode #(
    parameter int SEL_W = 8,
    parameter int AMT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic [AMT_W-1:0] amt,
    output logic             hit,
    output logic             bad
);
    localparam logic [SEL_W-1:0] ONE = {{(SEL_W-1){1'b0}}, 1'b1};

    always_comb begin
        amt = '0;
        for (int k = 0; k < SEL_W; k++) begin
            if (sel[SEL_W-1-k]) amt = k[AMT_W-1:0];
        end
    end

    assign hit = |sel;
    assign bad = hit && ((sel & (sel - ONE)) != '0);

    // R3
    zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> (!hit && !bad));

    // R6
    multi_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sel) > 1) |-> bad);

    // R2
    msb_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[SEL_W-1] && !bad) |-> (amt == '0));
endmodule

// File: rtl/pow2w_shift.sv
module pow2w_shift
    import pow2w_pkg::*;
#(
    parameter int SEL_W = 8,
    parameter int AMT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACT_W-1:0]  act,
    input  logic [AMT_W-1:0]  amt,
    output logic [PROD_W-1:0] shifted
);
    logic signed [PROD_W-1:0] aligned;
    logic        [PROD_W-1:0] cand [SEL_W];

    assign aligned = {act, {PAD_W{1'b0}}};

    for (genvar g = 0; g < SEL_W; g++) begin : g_tap
        assign cand[g] = aligned >>> g;
    end

    assign shifted = cand[amt];

    // R1
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (amt == '0) |-> (shifted[PROD_W-1 -: ACT_W] == act && shifted[PAD_W-1:0] == '0));

    // R4
    sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shifted[PROD_W-1] == act[ACT_W-1]);
endmodule

// File: rtl/pow2w_negate.sv
module pow2w_negate
    import pow2w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PROD_W-1:0] shifted,
    input  logic              neg,
    input  logic              hit,
    input  logic              bad,
    output logic [PROD_W-1:0] prod
);
    logic [PROD_W-1:0] signed_val;
    logic [PROD_W-1:0] sum_chk;

    assign signed_val = neg ? (~shifted + 1'b1) : shifted;
    assign prod       = (hit && !bad) ? signed_val : '0;
    assign sum_chk    = prod + shifted;

    // R5
    negate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !bad && neg) |-> (sum_chk == '0));

    // R6
    bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad |-> (prod == '0));
endmodule

// File: rtl/pow2w_mult.sv
module pow2w_mult
    import pow2w_pkg::*;
#(
    parameter int SHIFT_MAX = 7,
    parameter bit OUT_REG   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ACT_W-1:0]     act_i,
    input  logic [SHIFT_MAX:0]   sel_i,
    input  logic                 neg_i,
    output logic [PROD_W-1:0]    prod_o,
    output logic                 err_o
);
    localparam int SEL_W = SHIFT_MAX + 1;
    localparam int AMT_W = (SEL_W > 2) ? $clog2(SEL_W) : 1;

    logic [AMT_W-1:0]  amt;
    logic              hit;
    logic              bad;
    logic [PROD_W-1:0] shifted;
    logic [PROD_W-1:0] prod_next;

    pow2w_decode #(.SEL_W(SEL_W), .AMT_W(AMT_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .sel(sel_i),
        .amt(amt), .hit(hit), .bad(bad)
    );

    pow2w_shift #(.SEL_W(SEL_W), .AMT_W(AMT_W)) u_shf (
        .clk(clk), .rst_n(rst_n), .act(act_i),
        .amt(amt), .shifted(shifted)
    );

    pow2w_negate u_neg (
        .clk(clk), .rst_n(rst_n), .shifted(shifted), .neg(neg_i),
        .hit(hit), .bad(bad), .prod(prod_next)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prod_o <= '0;
                err_o  <= 1'b0;
            end else begin
                prod_o <= prod_next;
                err_o  <= bad;
            end
        end

        // R7
        out_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (prod_o == $past(prod_next) && err_o == $past(bad)));
    end else begin : g_comb
        assign prod_o = prod_next;
        assign err_o  = bad;
    end

    // R3
    zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (OUT_REG == 1'b0 && sel_i == '0) |-> (prod_o == '0 && !err_o));
endmodule

// File: tb/pow2w_mult_bench.sv
module pow2w_mult_bench;
    localparam int SHIFT_MAX = 7;
    localparam int SEL_W     = SHIFT_MAX + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        act_i = 8'h00;
    logic [SEL_W-1:0]  sel_i = '0;
    logic              neg_i = 1'b0;
    logic [15:0]       prod_o;
    logic              err_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pow2w_mult #(.SHIFT_MAX(SHIFT_MAX), .OUT_REG(1'b1)) u_pow2w_mult (
        .clk(clk), .rst_n(rst_n), .act_i(act_i), .sel_i(sel_i),
        .neg_i(neg_i), .prod_o(prod_o), .err_o(err_o)
    );

    function automatic logic [15:0] model_prod(logic [7:0] a, logic [SEL_W-1:0] s, logic n);
        logic signed [15:0] base;
        logic signed [15:0] sh;
        int k;
        if ($countones(s) != 1) return 16'h0000;
        k = 0;
        for (int i = 0; i < SEL_W; i++) if (s[SEL_W-1-i]) k = i;
        base = {a, 8'h00};
        sh = base >>> k;
        return n ? 16'(-sh) : sh;
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(string req, logic [7:0] a, logic [SEL_W-1:0] s, logic n);
        @(negedge clk);
        act_i = a; sel_i = s; neg_i = n;
        @(negedge clk);
        check(req, prod_o, model_prod(a, s, n));
        check({req, " err"}, {15'd0, err_o}, {15'd0, $countones(s) > 1});
    endtask

    task automatic t_reset;
        act_i = 8'h55; sel_i = {1'b1, {(SEL_W-1){1'b0}}}; neg_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 reset prod", prod_o, 16'h0000);
        check("R7 reset err", {15'd0, err_o}, 16'h0000);
        rst_n = 1'b1;
    endtask

    task automatic t_align;
        apply("R1 align 0x55", 8'h55, {1'b1, {(SEL_W-1){1'b0}}}, 1'b0);
        check("R1 literal", prod_o, 16'h5500);
        apply("R1 align 0xC3", 8'hC3, {1'b1, {(SEL_W-1){1'b0}}}, 1'b0);
        check("R1 literal neg act", prod_o, 16'hC300);
    endtask

    task automatic t_shifts;
        for (int k = 0; k < SEL_W; k++) begin
            logic [SEL_W-1:0] s = '0;
            s[SEL_W-1-k] = 1'b1;
            apply("R2 shift", 8'h7F, s, 1'b0);
        end
        apply("R2 shift1 literal", 8'h40, {2'b01, {(SEL_W-2){1'b0}}}, 1'b0);
        check("R2 value", prod_o, 16'h2000);
    endtask

    task automatic t_zero;
        apply("R3 zero pos", 8'h7F, '0, 1'b0);
        apply("R3 zero neg", 8'h80, '0, 1'b1);
        check("R3 literal", prod_o, 16'h0000);
    endtask

    task automatic t_fill;
        for (int k = 1; k < SEL_W; k++) begin
            logic [SEL_W-1:0] s = '0;
            s[SEL_W-1-k] = 1'b1;
            apply("R4 fill", 8'h81, s, 1'b0);
        end
        apply("R4 fill x2", 8'h80, {2'b01, {(SEL_W-2){1'b0}}}, 1'b0);
        check("R4 literal", prod_o, 16'hC000);
    endtask

    task automatic t_negate;
        apply("R5 neg", 8'h40, {1'b1, {(SEL_W-1){1'b0}}}, 1'b1);
        check("R5 literal", prod_o, 16'hC000);
        apply("R5 neg shift", 8'hF0, {3'b001, {(SEL_W-3){1'b0}}}, 1'b1);
        check("R5 literal2", prod_o, 16'h0400);
    endtask

    task automatic t_illegal;
        apply("R6 two hot", 8'h7F, {2'b11, {(SEL_W-2){1'b0}}}, 1'b0);
        check("R6 flag", {15'd0, err_o}, 16'h0001);
        apply("R6 all hot", 8'h12, '1, 1'b1);
        check("R6 prod", prod_o, 16'h0000);
        apply("R6 clears", 8'h12, {1'b1, {(SEL_W-1){1'b0}}}, 1'b0);
        check("R6 flag low", {15'd0, err_o}, 16'h0000);
    endtask

    task automatic t_latency;
        @(negedge clk);
        act_i = 8'h11; sel_i = {1'b1, {(SEL_W-1){1'b0}}}; neg_i = 1'b0;
        @(negedge clk);
        act_i = 8'h22;
        #1;
        check("R7 hold before edge", prod_o, 16'h1100);
        @(negedge clk);
        check("R7 after edge", prod_o, 16'h2200);
    endtask

    task automatic t_count;
        logic [15:0] seen [2*SEL_W+1];
        int n = 0;
        int distinct = 0;
        for (int sg = 0; sg < 2; sg++) begin
            for (int k = 0; k < SEL_W; k++) begin
                logic [SEL_W-1:0] s = '0;
                s[SEL_W-1-k] = 1'b1;
                apply("R8 sweep", 8'h40, s, sg[0]);
                seen[n] = prod_o; n++;
            end
        end
        apply("R8 zero", 8'h40, '0, 1'b0);
        seen[n] = prod_o; n++;
        for (int i = 0; i < n; i++) begin
            bit dup = 1'b0;
            for (int j = 0; j < i; j++) if (seen[j] == seen[i]) dup = 1'b1;
            if (!dup) distinct++;
        end
        check("R8 distinct", 16'(distinct), 16'(2*SHIFT_MAX+3));
    endtask

    task automatic t_wrap;
        apply("R9 wrap", 8'h80, {1'b1, {(SEL_W-1){1'b0}}}, 1'b1);
        check("R9 literal", prod_o, 16'h8000);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_align;
        t_shifts;
        t_zero;
        t_fill;
        t_negate;
        t_illegal;
        t_latency;
        t_count;
        t_wrap;
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule